// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a segmented logical address into a physical address. A request carries three items: a segment number, a 16-bit offset and an access kind (read, write or execute). The segment number indexes a small table held in registers. Each table row has a physical base, a segment length, a validity flag and three permission flags.

In one combinational step the block checks the validity flag and the programmable table length. It then compares the offset with the segment length and the access kind with the permission flags. The result is written to an output register and appears one cycle after the request. A correct result is the base plus the offset. A faulting result returns a fault code and a zero address.

Table rows and the table-length register are loaded through a write port. Supervisor code uses this port to reload the table for each new process.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid` is 0, every table row is invalid, and the table length is NUM_SEG (16).
- R2: `rsp_valid` in a cycle equals `req_valid` in the previous cycle. `rsp_fault` and `rsp_paddr` are registered results of the request sampled at that edge.
- R3: A segment number greater than or equal to the table length gives fault code 1 (invalid segment).
- R4: A segment whose validity flag is 0 gives fault code 1, whatever the offset or access kind.
- R5: On a valid segment, an offset greater than or equal to the segment length gives fault code 2 (bounds). Bounds has lower priority than invalid segment and higher priority than permission.
- R6: Access kinds are coded as 0 = read, 1 = write, 2 = execute; code 3 is reserved. Permission flags are bit 0 = read, bit 1 = write, bit 2 = execute. An in-bounds access whose flag is clear, or any access with code 3, gives fault code 3 (permission).
- R7: With no fault, fault code 0 is returned and the physical address is (base + offset) modulo 2^24.
- R8: With any nonzero fault code, the physical address is 0.
- R9: A table write is seen by requests from the next cycle on. A request in the same cycle as a write to its row uses the old contents.
- R10: A table-length write sets the number of usable segments. A length of 0 makes every segment invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one table row |
| wr_idx | input | 4 | Row to write |
| wr_base | input | 24 | Physical base of the row |
| wr_limit | input | 16 | Segment length in bytes |
| wr_valid | input | 1 | Validity flag |
| wr_perm | input | 3 | Permission flags: bit 0 read, bit 1 write, bit 2 execute |
| len_wr_en | input | 1 | Load the table-length register |
| len_value | input | 5 | New table length (0 to 16) |
| req_valid | input | 1 | Translation request |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result present |
| rsp_fault | output | 2 | 0 none, 1 invalid segment, 2 bounds, 3 permission |
| rsp_paddr | output | 24 | Physical address, 0 on fault |

## Verification
A corrupted table row shows up at the outputs on the first request that indexes it. The symptom is a wrong address or a fault code that moves to a different priority, and it appears one cycle after that request. A wrong length register changes the invalid-segment boundary for every segment number above it. So a sweep over all segments, all access kinds and offsets at both edges of each limit exposes any such fault within one pass. Same-cycle write and request pairs show whether the table update is one cycle late or early.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_BOUNDS  = 2'd2,
    FLT_PERM    = 2'd3
  } fault_e;

  localparam int PERM_W = 3;
endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table #(
  parameter int NUM_SEG = 16,
  parameter int IDX_W   = 4,
  parameter int BASE_W  = 24,
  parameter int LIM_W   = 16,
  parameter int PERM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              wr_valid,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output logic              rd_valid,
  output logic [PERM_W-1:0] rd_perm
);
  logic [BASE_W-1:0] base_q  [NUM_SEG];
  logic [LIM_W-1:0]  limit_q [NUM_SEG];
  logic              valid_q [NUM_SEG];
  logic [PERM_W-1:0] perm_q  [NUM_SEG];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_row
    logic row_we;
    assign row_we = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        valid_q[i] <= 1'b0;
        perm_q[i]  <= '0;
      end else if (row_we) begin
        base_q[i]  <= wr_base;
        limit_q[i] <= wr_limit;
        valid_q[i] <= wr_valid;
        perm_q[i]  <= wr_perm;
      end
    end
  end

  always_comb begin
    rd_base  = '0;
    rd_limit = '0;
    rd_valid = 1'b0;
    rd_perm  = '0;
    for (int k = 0; k < NUM_SEG; k++) begin
      if (rd_idx == IDX_W'(k)) begin
        rd_base  = base_q[k];
        rd_limit = limit_q[k];
        rd_valid = valid_q[k];
        rd_perm  = perm_q[k];
      end
    end
  end
endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
  import seg_xlate_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int LEN_W  = 5,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16
) (
  input  logic [IDX_W-1:0]  seg,
  input  logic [LIM_W-1:0]  off,
  input  logic [1:0]        acc,
  input  logic [LEN_W-1:0]  tbl_len,
  input  logic [BASE_W-1:0] base,
  input  logic [LIM_W-1:0]  limit,
  input  logic              valid,
  input  logic [PERM_W-1:0] perm,
  output fault_e            fault,
  output logic [BASE_W-1:0] paddr
);
  logic beyond_len;
  logic out_of_bounds;
  logic perm_ok;

  always_comb begin
    beyond_len    = LEN_W'(seg) >= tbl_len;
    out_of_bounds = off >= limit;
    unique case (acc)
      ACC_READ:  perm_ok = perm[0];
      ACC_WRITE: perm_ok = perm[1];
      ACC_EXEC:  perm_ok = perm[2];
      default:   perm_ok = 1'b0;
    endcase

    if (beyond_len || !valid)  fault = FLT_INVALID;
    else if (out_of_bounds)    fault = FLT_BOUNDS;
    else if (!perm_ok)         fault = FLT_PERM;
    else                       fault = FLT_NONE;

    paddr = (fault == FLT_NONE) ? (base + BASE_W'(off)) : '0;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16,
  parameter int IDX_W   = 4,
  parameter int BASE_W  = 24,
  parameter int LIM_W   = 16,
  localparam int LEN_W  = $clog2(NUM_SEG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              wr_valid,
  input  logic [2:0]        wr_perm,
  input  logic              len_wr_en,
  input  logic [LEN_W-1:0]  len_value,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_seg,
  input  logic [LIM_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  output logic [1:0]        rsp_fault,
  output logic [BASE_W-1:0] rsp_paddr
);
  logic [BASE_W-1:0] ent_base;
  logic [LIM_W-1:0]  ent_limit;
  logic              ent_valid;
  logic [PERM_W-1:0] ent_perm;
  logic [LEN_W-1:0]  seg_len_q;
  logic [LEN_W-1:0]  seg_len_d;
  fault_e            fault_c;
  logic [BASE_W-1:0] paddr_c;
  logic [1:0]        fault_d;
  logic [BASE_W-1:0] paddr_d;

  seg_xlate_table #(
    .NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .BASE_W(BASE_W),
    .LIM_W(LIM_W), .PERM_W(PERM_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_valid(wr_valid), .wr_perm(wr_perm),
    .rd_idx(req_seg), .rd_base(ent_base), .rd_limit(ent_limit),
    .rd_valid(ent_valid), .rd_perm(ent_perm)
  );

  seg_xlate_check #(
    .IDX_W(IDX_W), .LEN_W(LEN_W), .BASE_W(BASE_W), .LIM_W(LIM_W)
  ) u_check (
    .seg(req_seg), .off(req_off), .acc(req_acc), .tbl_len(seg_len_q),
    .base(ent_base), .limit(ent_limit), .valid(ent_valid),
    .perm(ent_perm), .fault(fault_c), .paddr(paddr_c)
  );

  // next-state
  always_comb begin
    seg_len_d = len_wr_en ? len_value : seg_len_q;
    fault_d   = req_valid ? fault_c : rsp_fault;
    paddr_d   = req_valid ? paddr_c : rsp_paddr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_len_q <= LEN_W'(NUM_SEG);
      rsp_valid <= 1'b0;
      rsp_fault <= '0;
      rsp_paddr <= '0;
    end else begin
      seg_len_q <= seg_len_d;
      rsp_valid <= req_valid;
      rsp_fault <= fault_d;
      rsp_paddr <= paddr_d;
    end
  end
endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk #(
  parameter int IDX_W  = 4,
  parameter int LEN_W  = 5,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [IDX_W-1:0]  req_seg,
  input logic [LIM_W-1:0]  req_off,
  input logic [1:0]        req_acc,
  input logic [LEN_W-1:0]  seg_len_q,
  input logic              rsp_valid,
  input logic [1:0]        rsp_fault,
  input logic [BASE_W-1:0] rsp_paddr
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  beyond_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (LEN_W'(req_seg) >= seg_len_q)) |=> (rsp_fault == 2'd1));

  // R5
  max_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_off == '1)) |=> (rsp_fault == 2'd1 || rsp_fault == 2'd2));

  // R6
  reserved_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_acc == 2'd3) |=> (rsp_fault != 2'd0));

  // R8
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
endmodule

bind seg_xlate_unit seg_xlate_unit_chk #(
  .IDX_W(IDX_W), .LEN_W(LEN_W), .BASE_W(BASE_W), .LIM_W(LIM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
  .req_off(req_off), .req_acc(req_acc), .seg_len_q(seg_len_q),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/seg_xlate_unit_bench.sv
`timescale 1ns/1ps
module seg_xlate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_valid, len_wr_en, req_valid;
  logic [3:0]  wr_idx, req_seg;
  logic [23:0] wr_base;
  logic [15:0] wr_limit, req_off;
  logic [2:0]  wr_perm;
  logic [4:0]  len_value;
  logic [1:0]  req_acc;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [23:0] rsp_paddr;

  int n_cmp = 0;
  int n_bad = 0;

  int base_m [16];
  int lim_m  [16];
  bit val_m  [16];
  bit [2:0] perm_m [16];
  int len_m;

  always #2 clk = ~clk;

  seg_xlate_unit u_seg_xlate_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_valid(wr_valid),
    .wr_perm(wr_perm), .len_wr_en(len_wr_en), .len_value(len_value),
    .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
    .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_fault(input int s, input int o, input int a);
    if (s >= len_m || !val_m[s]) return 1;
    if (o >= lim_m[s]) return 2;
    if (a == 3 || !perm_m[s][a]) return 3;
    return 0;
  endfunction

  task automatic load_row(input int i, input int b, input int l, input bit v, input bit [2:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(i); wr_base = 24'(b); wr_limit = 16'(l);
    wr_valid = v; wr_perm = p;
    @(negedge clk);
    wr_en = 1'b0;
    base_m[i] = b & 24'hFFFFFF; lim_m[i] = l; val_m[i] = v; perm_m[i] = p;
  endtask

  task automatic set_len(input int n);
    @(negedge clk);
    len_wr_en = 1'b1; len_value = 5'(n);
    @(negedge clk);
    len_wr_en = 1'b0;
    len_m = n;
  endtask

  // drives one request and checks it against the model, naming the requirement
  task automatic probe(input int s, input int o, input int a);
    int f, pa;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_seg = 4'(s); req_off = 16'(o); req_acc = 2'(a);
    f  = exp_fault(s, o, a);
    pa = (f == 0) ? ((base_m[s] + o) & 24'hFFFFFF) : 0;
    case (f)
      0: tag = "R7";
      1: tag = (s >= len_m) ? "R3" : "R4";
      2: tag = "R5";
      default: tag = "R6";
    endcase
    @(negedge clk);
    req_valid = 1'b0;
    cmp("R2 rsp_valid", int'(rsp_valid), 1);
    cmp(tag, int'(rsp_fault), f);
    cmp((f == 0) ? "R7 paddr" : "R8 paddr", int'(rsp_paddr), pa);
  endtask

  task automatic sweep();
    for (int s = 0; s < 16; s++)
      for (int a = 0; a < 4; a++) begin
        probe(s, 0, a);
        probe(s, (lim_m[s] - 1) & 16'hFFFF, a);
        probe(s, lim_m[s] & 16'hFFFF, a);
        probe(s, 16'hFFFF, a);
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_idx = 0; wr_base = 0; wr_limit = 0; wr_valid = 0; wr_perm = 0;
    len_wr_en = 0; len_value = 0; req_valid = 0; req_seg = 0; req_off = 0; req_acc = 0;
    for (int i = 0; i < 16; i++) begin
      base_m[i] = 0; lim_m[i] = 0; val_m[i] = 0; perm_m[i] = 0;
    end
    len_m = 16;
    repeat (3) @(negedge clk);
    cmp("R1 rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 rsp_valid after reset", int'(rsp_valid), 0);
    // R1: every row invalid, length 16
    for (int s = 0; s < 16; s++) probe(s, 0, 0);
    @(negedge clk);
    cmp("R2 idle", int'(rsp_valid), 0);

    // fill table: row 5 invalid, row 15 base wraps, row 0 zero length
    for (int i = 0; i < 16; i++)
      load_row(i, (i * 32'h111111) + 32'h100 * i, i * 32'h1000 + (i == 0 ? 0 : 16'h80),
               i != 5, 3'(i));
    load_row(15, 24'hFFFF00, 16'h4000, 1'b1, 3'b111);
    sweep();

    // R10: shorter table, then empty table
    set_len(10);
    sweep();
    set_len(0);
    for (int s = 0; s < 16; s++) probe(s, 0, 0);
    set_len(16);

    // R9: write and request in the same cycle see old contents
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd3; wr_base = 24'h000200; wr_limit = 16'h0100;
    wr_valid = 1; wr_perm = 3'b010;
    req_valid = 1; req_seg = 4'd3; req_off = 16'h10; req_acc = 2'd0;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    cmp("R9 old fault", int'(rsp_fault), exp_fault(3, 16'h10, 0));
    cmp("R9 old paddr", int'(rsp_paddr), (base_m[3] + 16'h10) & 24'hFFFFFF);
    base_m[3] = 24'h000200; lim_m[3] = 16'h0100; val_m[3] = 1; perm_m[3] = 3'b010;
    probe(3, 16'h10, 0);
    probe(3, 16'h10, 1);
    probe(3, 16'hFF, 1);
    probe(3, 16'h100, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule